// File: doc/BRIEF.md
# Systolic Tri-Diagonal Matrix-Vector Multiplier

This block computes y = A·x for a square band matrix whose non-zero entries lie on the main diagonal and the two diagonals beside it. It does this with a row of three processing cells, one for each diagonal. The vector elements enter at the left end and move one cell to the right each cycle. The partial sums start at zero, enter at the right end and move one cell to the left each cycle. In both streams an empty slot separates each element from the next. Every partial sum y_i therefore meets each x_j it needs in exactly one cell, and that cell adds a(i,j)·x_j into the sum as it passes.

The whole vector is loaded in parallel when a run starts. Each cell has its own coefficient lane with a valid strobe. The environment places the coefficient on that lane in the cycle when the matching x and partial sum are inside the cell. Finished sums leave at the left end in index order, each marked by a valid strobe. At the end of a run the block gives a done pulse and the number of cycles the array took.

Top module: `sbm_band_mv`

## Requirements
- R1: After reset, y_vld, done and busy are low, and y_out and cyc_count are zero.
- R2: A cell that accumulates replaces the passing sum s with s + a·x. Here a and x are DW-bit two's-complement values and the product is sign-extended to AW bits. The addition wraps modulo 2^AW with no saturation.
- R3: Cycle 0 is the cycle after the clock edge at which start is sampled high while busy is low. Element x_k is present in the leftmost cell (cell 0) in cycle 2k. A zero partial sum for row k is present in the rightmost cell (cell 2) in cycle 2k. x moves one cell to the right per cycle and the partial sums move one cell to the left per cycle.
- R4: Cell c serves the entries a(i,j) with j = i + 1 − c. The coefficient a(i,j) is used when it is on lane c of a_in, bits [DW·c+DW−1 : DW·c], with a_vld[c] high during cycle 2j + c.
- R5: A cell adds only when its x slot, its partial-sum slot and its coefficient strobe are all valid in the same cycle. Otherwise the sum passes through unchanged, and lane data without a strobe has no effect on the results.
- R6: Result y_i is on y_out with y_vld high during cycle 2i + 3, for i = 0 … N−1 in index order. y_vld is never high in two consecutive cycles.
- R7: busy is high from cycle 0 through cycle 2N+1. done is high for exactly one cycle, cycle 2N+2.
- R8: Starting a run clears cyc_count to 0. From cycle 2N+1 on, cyc_count holds 2N+1, which is the number of cycles from cycle 0 up to and including the cycle in which the last sum is in the leftmost cell. It keeps this value until the next run starts. With N = 8 the value is 17.
- R9: start is ignored while busy is high. Such a pulse does not restart the schedule and does not change the results.
- R10: Element x_k is taken from x_vec bits [DW·k+DW−1 : DW·k] at the start edge. Changes on x_vec during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| x_vec | input | N·DW | Packed input vector, element k in slice k |
| a_in | input | 3·DW | One coefficient lane per cell |
| a_vld | input | 3 | Strobe per coefficient lane |
| y_out | output | AW | Finished row sum |
| y_vld | output | 1 | y_out holds a new result |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cyc_count | output | $clog2(2N+3) | Array cycles used by the last run |

## Verification
The assertions check the following on every cycle:
- x values travel unchanged from cell to cell.
- A partial sum crosses a cell without an accumulate unchanged.
- The output strobes keep their one-slot spacing.
- done is a single-cycle pulse that coincides with a count of 2N+1.
- A start pulse during a run neither resets the schedule nor disturbs the captured vector.

The following can only be shown by the bench scenarios, which compare each result with a sum formed independently:
- The numerical results.
- The coefficient timing on each lane.
- Wrap-around on overflow.
- That a withheld strobe removes exactly one term.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  // Three cells: super-diagonal, main diagonal, sub-diagonal.
  localparam int unsigned SBM_CELLS = 3;

  // Cycles from the first x in the left cell to the last sum leaving it.
  function automatic int run_cycles(input int n);
    return 2 * n + 1;
  endfunction

endpackage

// File: rtl/sbm_cell.sv
module sbm_cell #(
  parameter int DW = 16,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] x_ld,
  input  logic                 xv_ld,
  input  logic signed [AW-1:0] y_ld,
  input  logic                 yv_ld,
  input  logic signed [DW-1:0] a,
  input  logic                 av,
  output logic signed [DW-1:0] x_q,
  output logic                 xv_q,
  output logic signed [AW-1:0] y_q,
  output logic                 yv_q,
  output logic signed [AW-1:0] y_res,
  output logic                 acc
);

  // Multiply-accumulate with sign-extended product and wrap-around sum.
  function automatic logic signed [AW-1:0] mac(
    input logic signed [AW-1:0] s,
    input logic signed [DW-1:0] c,
    input logic signed [DW-1:0] v
  );
    logic signed [2*DW-1:0] p;
    logic signed [AW-1:0]   pe;
    p  = c * v;
    pe = AW'(p);
    return s + pe;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      xv_q <= 1'b0;
      y_q  <= '0;
      yv_q <= 1'b0;
    end else begin
      x_q  <= x_ld;
      xv_q <= xv_ld;
      y_q  <= y_ld;
      yv_q <= yv_ld;
    end
  end

  assign acc   = xv_q && yv_q && av;
  assign y_res = acc ? mac(y_q, a, x_q) : y_q;

endmodule

// File: rtl/sbm_feeder.sv
module sbm_feeder #(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int CW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N*DW-1:0]      x_vec,
  output logic                 inj_v,
  output logic signed [DW-1:0] inj_x,
  output logic                 busy,
  output logic                 done,
  output logic [CW-1:0]        cyc_count
);
  import sbm_pkg::*;

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_T = CW'(2 * N);
  localparam logic [CW-1:0] END_T  = CW'(2 * N + 1);
  localparam logic [CW-2:0] NK     = (CW-1)'(N);

  logic signed [DW-1:0] xbuf_q [N];
  logic                 busy_q, done_q;
  logic [CW-1:0]        t_q, cnt_q, tn;
  logic [CW-2:0]        k;
  logic                 accept;

  assign accept = start && !busy_q;
  assign tn     = t_q + 1'b1;
  assign k      = tn[CW-1:1];

  // One element per two cycles: x into the left cell, a zero sum into the right.
  always_comb begin
    inj_v = 1'b0;
    inj_x = '0;
    if (accept) begin
      inj_v = 1'b1;
      inj_x = $signed(x_vec[DW-1:0]);
    end else if (busy_q && !tn[0] && (k < NK)) begin
      inj_v = 1'b1;
      inj_x = xbuf_q[k[IW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      t_q    <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < N; i++) xbuf_q[i] <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      t_q    <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < N; i++) xbuf_q[i] <= $signed(x_vec[i*DW +: DW]);
    end else if (busy_q) begin
      t_q <= tn;
      if (t_q == LAST_T) cnt_q <= tn;
      if (t_q == END_T) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign cyc_count = cnt_q;

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && t_q != END_T) |=> (busy_q && t_q != '0));

  assert_xbuf_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(xbuf_q[N-1]));

  assert_done_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == CW'(run_cycles(N))));

endmodule

// File: rtl/sbm_band_mv.sv
module sbm_band_mv
  import sbm_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int AW = 32,
  localparam int CW = $clog2(2 * N + 3)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [N*DW-1:0]         x_vec,
  input  logic [SBM_CELLS*DW-1:0] a_in,
  input  logic [SBM_CELLS-1:0]    a_vld,
  output logic [AW-1:0]           y_out,
  output logic                    y_vld,
  output logic                    busy,
  output logic                    done,
  output logic [CW-1:0]           cyc_count
);

  localparam int NC = SBM_CELLS;

  logic                 inj_v;
  logic signed [DW-1:0] inj_x;

  logic signed [DW-1:0] x_q   [NC];
  logic                 xv_q  [NC];
  logic signed [AW-1:0] y_q   [NC];
  logic                 yv_q  [NC];
  logic signed [AW-1:0] y_res [NC];
  logic                 acc   [NC];

  sbm_feeder #(.N(N), .DW(DW), .CW(CW)) u_feed (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .x_vec     (x_vec),
    .inj_v     (inj_v),
    .inj_x     (inj_x),
    .busy      (busy),
    .done      (done),
    .cyc_count (cyc_count)
  );

  for (genvar c = 0; c < NC; c++) begin : g_cell
    logic signed [DW-1:0] xl;
    logic                 xvl;
    logic signed [AW-1:0] yl;
    logic                 yvl;

    if (c == 0) begin : g_xl
      assign xl  = inj_x;
      assign xvl = inj_v;
    end else begin : g_xn
      assign xl  = x_q[c-1];
      assign xvl = xv_q[c-1];
    end

    if (c == NC - 1) begin : g_yr
      assign yl  = '0;
      assign yvl = inj_v;
    end else begin : g_yn
      assign yl  = y_res[c+1];
      assign yvl = yv_q[c+1];
    end

    sbm_cell #(.DW(DW), .AW(AW)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .x_ld  (xl),
      .xv_ld (xvl),
      .y_ld  (yl),
      .yv_ld (yvl),
      .a     ($signed(a_in[c*DW +: DW])),
      .av    (a_vld[c]),
      .x_q   (x_q[c]),
      .xv_q  (xv_q[c]),
      .y_q   (y_q[c]),
      .yv_q  (yv_q[c]),
      .y_res (y_res[c]),
      .acc   (acc[c])
    );

    if (c > 0) begin : g_chk_x
      assert_x_travel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xv_q[c] |-> ($past(xv_q[c-1]) && x_q[c] == $past(x_q[c-1])));
    end

    if (c < NC - 1) begin : g_chk_y
      assert_pass_unchanged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (yv_q[c] && !$past(acc[c+1])) |-> (y_q[c] == $past(y_q[c+1])));
    end
  end

  // Result register at the left end.
  logic [AW-1:0] y_out_q;
  logic          y_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_out_q <= '0;
      y_vld_q <= 1'b0;
    end else begin
      y_vld_q <= yv_q[0];
      if (yv_q[0]) y_out_q <= y_res[0];
    end
  end

  assign y_out = y_out_q;
  assign y_vld = y_vld_q;

  assert_y_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld_q |=> !y_vld_q);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/tb_sbm_band_mv.sv
module tb_sbm_band_mv;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int AW = 32;
  localparam int CW = $clog2(2 * N + 3);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [N*DW-1:0] x_vec = '0;
  logic [3*DW-1:0] a_in = '0;
  logic [2:0]      a_vld = '0;
  logic [AW-1:0]   y_out;
  logic            y_vld, busy, done;
  logic [CW-1:0]   cyc_count;

  always #5 clk = ~clk;

  sbm_band_mv #(.N(N), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_vec(x_vec),
    .a_in(a_in), .a_vld(a_vld), .y_out(y_out), .y_vld(y_vld),
    .busy(busy), .done(done), .cyc_count(cyc_count)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int A [N][N];
  int X [N];
  int drop_i = -1, drop_j = -1;
  int unsigned seed = 32'h1234_5678;

  function automatic int rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[30:15]));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Row sum over the band, formed in 64 bits and then cut to the accumulator width.
  function automatic logic [AW-1:0] row_sum(input int i);
    longint s = 0;
    for (int j = i - 1; j <= i + 1; j++)
      if (j >= 0 && j < N && !(i == drop_i && j == drop_j))
        s += longint'(A[i][j]) * longint'(X[j]);
    return s[AW-1:0];
  endfunction

  // Lane c carries a(i,j) with j = i+1-c during cycle 2j+c (R4).
  task automatic drive_lanes(input int t);
    for (int c = 0; c < 3; c++) begin
      int j, i;
      a_vld[c] = 1'b0;
      a_in[c*DW +: DW] = 16'(16'h5A5A ^ t ^ (c << 8));
      if (t - c >= 0 && ((t - c) % 2) == 0) begin
        j = (t - c) / 2;
        i = j + c - 1;
        if (i >= 0 && i < N && j < N && !(i == drop_i && j == drop_j)) begin
          a_vld[c] = 1'b1;
          a_in[c*DW +: DW] = 16'(A[i][j]);
        end
      end
    end
  endtask

  task automatic load_x();
    for (int k = 0; k < N; k++) x_vec[k*DW +: DW] = 16'(X[k]);
  endtask

  // Full run; disturb pulses start with a different vector during cycle 5.
  task automatic run_case(input string name, input bit disturb);
    load_x();
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int t = 0; t <= 2 * N + 3; t++) begin
      drive_lanes(t);
      if (disturb && t == 5) begin start = 1'b1; x_vec = ~x_vec; end
      if (disturb && t == 6) start = 1'b0;
      @(negedge clk);
      if (t >= 3 && (t % 2) == 1 && (t - 3) / 2 < N) begin
        int i = (t - 3) / 2;
        check(y_vld === 1'b1, {name, " R6 y_vld"}, y_vld, 1);
        check(y_out === row_sum(i), {name, " R2 R4 y value"}, $signed(y_out), $signed(row_sum(i)));
      end else begin
        check(y_vld === 1'b0, {name, " R6 idle slot"}, y_vld, 0);
      end
      if (t == 0) check(cyc_count == 0, {name, " R8 cleared"}, cyc_count, 0);
      check(busy === (t <= 2 * N + 1), {name, " R7 busy"}, busy, t <= 2 * N + 1);
      check(done === (t == 2 * N + 2), {name, " R7 done"}, done, t == 2 * N + 2);
      if (t >= 2 * N + 1)
        check(cyc_count == CW'(2 * N + 1), {name, " R8 count"}, cyc_count, 2 * N + 1);
      @(posedge clk); #1;
    end
    a_vld = '0;
    drop_i = -1;
    drop_j = -1;
  endtask

  task automatic fill_band(input bit random, input int val);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        A[i][j] = (j >= i - 1 && j <= i + 1) ? (random ? rnd16() : val) : 0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(y_vld === 1'b0 && done === 1'b0 && busy === 1'b0, "R1 flags", {y_vld, done, busy}, 0);
    check(y_out === '0, "R1 y_out", y_out, 0);
    check(cyc_count === '0, "R1 count", cyc_count, 0);
  endtask

  task automatic test_simple();
    fill_band(0, 1);
    for (int k = 0; k < N; k++) X[k] = k + 1;
    run_case("simple R3", 0);
  endtask

  task automatic test_random();
    for (int r = 0; r < 3; r++) begin
      fill_band(1, 0);
      for (int k = 0; k < N; k++) X[k] = rnd16();
      run_case("random R2", 0);
    end
  endtask

  task automatic test_wrap();
    fill_band(0, -32768);
    for (int k = 0; k < N; k++) X[k] = -32768;
    run_case("wrap R2", 0);
  endtask

  task automatic test_drop();
    fill_band(1, 0);
    for (int k = 0; k < N; k++) X[k] = rnd16();
    drop_i = 3;
    drop_j = 4;
    run_case("drop R5", 0);
  endtask

  task automatic test_busy_start();
    fill_band(1, 0);
    for (int k = 0; k < N; k++) X[k] = rnd16();
    run_case("busy start R9 R10", 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    @(posedge clk); #1;
    test_simple();
    test_random();
    test_wrap();
    test_drop();
    test_busy_start();
    test_simple();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule